// File: doc/BRIEF.md
# Interrupt and Bus-Error Capture Unit

This block gathers the interrupt sources of one storage channel into a single interrupt line. Two events are tracked: a transfer-done indication and a bus error seen while the channel was moving data. Each event latches a pending bit. The interrupt line is raised while any pending bit has its enable set. On the first bus error the block records the full failing address. That address stays frozen until software acknowledges the error.

Software uses a small word-addressed register port. Through it, software reads pending bits, programs the enable mask, acknowledges bits with write-one-to-clear, and reads back the captured error address. The same window also maps the attached device's status byte. Reading that byte while the device reports not-busy with a service flag set acknowledges all pending bits as a side effect. A status poll therefore doubles as an interrupt acknowledge. Read data is registered and appears one cycle after the read strobe.

Top module: `irqcap_unit`

## Requirements
- R1: After a synchronous reset, the pending bits, the enable mask and both error-address words are zero, and `irq` is low.
- R2: A `done_evt` pulse sets pending bit 0 and a `buserr_evt` pulse sets pending bit 1. A read of word index 3 returns the pending bits in bits 1:0, with all other bits zero.
- R3: A write to word index 5 loads bits 1:0 of the write data as the enable mask, and a read of index 5 returns it. `irq` is high exactly when some pending bit has its enable bit set.
- R4: A write to word index 7 clears each pending bit whose data bit is 1. Bits written with 0 keep their value.
- R5: When an event arrives in the same cycle as a clear of its bit, whether by a write or by a status-read acknowledge, the event wins and the bit is set afterwards.
- R6: When a bus error arrives while pending bit 1 is clear, or while bit 1 is being cleared in that same cycle, `buserr_addr` is captured. Its low 32 bits are read at word index 0 and its high 32 bits at word index 1.
- R7: While pending bit 1 stays set, further bus errors do not change the captured address.
- R8: A read of word index 0x47 (byte offset 0x11C) returns `dev_status` zero-extended to 32 bits.
- R9: That read clears both pending bits when `dev_status` bit 7 (busy) is 0 and at least one of bits 0, 4 or 6 is 1.
- R10: A device-status read with bit 7 set, or with none of bits 0, 4, 6 set, leaves the pending bits unchanged. Reads of any other index also leave them unchanged.
- R11: A read of an unmapped index returns zero. Read data is valid in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Word index of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| done_evt | input | 1 | Transfer-done event pulse |
| buserr_evt | input | 1 | Bus-error event pulse |
| buserr_addr | input | 2*DATA_W | Address of the failing bus access |
| dev_status | input | 8 | Current device status byte |
| irq | output | 1 | Interrupt line |

## Verification
Pending bits and the captured address update at the clock edge that samples the event or the access. `irq` follows from registered state and is correct in the same cycle, after that edge. `reg_rdata` is due one edge after the read strobe. The bench drives inputs 1 ns after a rising edge and samples outputs 1 ns after the next one, so each result is checked exactly one edge after its stimulus. A behavioural reference model advances on the same edges and is compared against `irq` and `reg_rdata` on every cycle.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;

    localparam int SRC_N      = 2;
    localparam int SRC_DONE   = 0;
    localparam int SRC_BUSERR = 1;

    localparam int IDX_ERR_LO  = 0;
    localparam int IDX_ERR_HI  = 1;
    localparam int IDX_STAT    = 3;
    localparam int IDX_ENA     = 5;
    localparam int IDX_CLR     = 7;
    localparam int IDX_DEVSTAT = 'h47;

    localparam int           DEV_W         = 8;
    localparam int           DEV_BUSY_BIT  = 7;
    localparam logic [7:0]   DEV_FLAG_MASK = 8'h51;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef struct packed {
        logic err_lo;
        logic err_hi;
        logic stat;
        logic ena;
        logic clr;
        logic devstat;
    } sel_t;

    function automatic logic dev_ack_ok(input logic [DEV_W-1:0] s);
        return !s[DEV_BUSY_BIT] && (|(s & DEV_FLAG_MASK));
    endfunction

endpackage

// File: rtl/irqcap_decode.sv
module irqcap_decode
    import irqcap_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    always_comb begin
        sel         = '0;
        sel.err_lo  = (addr == ADDR_W'(IDX_ERR_LO));
        sel.err_hi  = (addr == ADDR_W'(IDX_ERR_HI));
        sel.stat    = (addr == ADDR_W'(IDX_STAT));
        sel.ena     = (addr == ADDR_W'(IDX_ENA));
        sel.clr     = (addr == ADDR_W'(IDX_CLR));
        sel.devstat = (addr == ADDR_W'(IDX_DEVSTAT));
    end
endmodule

// File: rtl/irqcap_pending.sv
module irqcap_pending
    import irqcap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt,
    input  src_vec_t clr_mask,
    output src_vec_t pend
);
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else if (evt[i])
                pend[i] <= 1'b1;
            else if (clr_mask[i])
                pend[i] <= 1'b0;
        end

        AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> pend[i]);  // R5
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (clr_mask[i] && !evt[i]) |=> !pend[i]);  // R4
        AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (!clr_mask[i] && !evt[i]) |=> (pend[i] == $past(pend[i])));  // R10
    end
endmodule

// File: rtl/irqcap_erraddr.sv
module irqcap_erraddr #(
    parameter int DATA_W = 32,
    localparam int EA_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_evt,
    input  logic              slot_free,
    input  logic [EA_W-1:0]   err_addr,
    output logic [DATA_W-1:0] addr_lo,
    output logic [DATA_W-1:0] addr_hi
);
    logic take;
    assign take = err_evt && slot_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lo <= '0;
            addr_hi <= '0;
        end else if (take) begin
            addr_lo <= err_addr[DATA_W-1:0];
            addr_hi <= err_addr[EA_W-1:DATA_W];
        end
    end

    AST_ADDR_TAKEN: assert property (@(posedge clk) disable iff (rst)
        take |=> ({addr_hi, addr_lo} == $past(err_addr)));  // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        !slot_free |=> ($stable(addr_lo) && $stable(addr_hi)));  // R7
endmodule

// File: rtl/irqcap_rdmux.sv
module irqcap_rdmux
    import irqcap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  sel_t              sel,
    input  src_vec_t          pend,
    input  src_vec_t          ena,
    input  logic [DATA_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] addr_hi,
    input  logic [DEV_W-1:0]  dev_status,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        unique case (1'b1)
            sel.err_lo:  rd_next = addr_lo;
            sel.err_hi:  rd_next = addr_hi;
            sel.stat:    rd_next = DATA_W'(pend);
            sel.ena:     rd_next = DATA_W'(ena);
            sel.devstat: rd_next = DATA_W'(dev_status);
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd)
            rdata <= rd_next;
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && !(|sel)) |=> (rdata == '0));  // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));  // R11
    AST_DEVSTAT_READ: assert property (@(posedge clk) disable iff (rst)
        (rd && sel.devstat) |=> (rdata == DATA_W'($past(dev_status))));  // R8
endmodule

// File: rtl/irqcap_unit.sv
module irqcap_unit
    import irqcap_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  done_evt,
    input  logic                  buserr_evt,
    input  logic [2*DATA_W-1:0]   buserr_addr,
    input  logic [DEV_W-1:0]      dev_status,
    output logic                  irq
);
    sel_t              sel;
    src_vec_t          evt;
    src_vec_t          clr_mask;
    src_vec_t          pend;
    src_vec_t          ena;
    logic              auto_ack;
    logic [DATA_W-1:0] addr_lo;
    logic [DATA_W-1:0] addr_hi;

    irqcap_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    assign evt[SRC_DONE]   = done_evt;
    assign evt[SRC_BUSERR] = buserr_evt;

    assign auto_ack = reg_rd && sel.devstat && dev_ack_ok(dev_status);

    always_comb begin
        clr_mask = '0;
        if (reg_wr && sel.clr)
            clr_mask = reg_wdata[SRC_N-1:0];
        if (auto_ack)
            clr_mask = '1;
    end

    irqcap_pending u_pend (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_mask (clr_mask),
        .pend     (pend)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ena <= '0;
        else if (reg_wr && sel.ena)
            ena <= reg_wdata[SRC_N-1:0];
    end

    irqcap_erraddr #(.DATA_W(DATA_W)) u_ea (
        .clk       (clk),
        .rst       (rst),
        .err_evt   (buserr_evt),
        .slot_free (!pend[SRC_BUSERR] || clr_mask[SRC_BUSERR]),
        .err_addr  (buserr_addr),
        .addr_lo   (addr_lo),
        .addr_hi   (addr_hi)
    );

    irqcap_rdmux #(.DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd         (reg_rd),
        .sel        (sel),
        .pend       (pend),
        .ena        (ena),
        .addr_lo    (addr_lo),
        .addr_hi    (addr_hi),
        .dev_status (dev_status),
        .rdata      (reg_rdata)
    );

    assign irq = |(pend & ena);

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq && (pend == '0) && (ena == '0)));  // R1
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (done_evt && ena[SRC_DONE] && !(reg_wr && sel.ena)) |=> irq);  // R3
    AST_AUTO_ACK: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && sel.devstat && !dev_status[DEV_BUSY_BIT]
         && (|(dev_status & DEV_FLAG_MASK)) && !done_evt && !buserr_evt)
        |=> (pend == '0));  // R9
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && sel.devstat && dev_status[DEV_BUSY_BIT] && !reg_wr)
        |=> (pend == $past(pend) | $past(evt)));  // R10
endmodule

// File: tb/sim_irqcap_unit.sv
module sim_irqcap_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        done_evt = 1'b0;
    logic        buserr_evt = 1'b0;
    logic [63:0] buserr_addr = '0;
    logic [7:0]  dev_status = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done_run = 1'b0;

    always #2.5 clk = ~clk;

    irqcap_unit u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_evt(done_evt), .buserr_evt(buserr_evt),
        .buserr_addr(buserr_addr), .dev_status(dev_status), .irq(irq)
    );

    // Behavioural reference model
    logic [1:0]  m_pend, m_en;
    logic [31:0] m_lo, m_hi, m_rd;

    always @(posedge clk) begin
        logic [1:0] cm;
        if (rst) begin
            m_pend = '0; m_en = '0; m_lo = '0; m_hi = '0; m_rd = '0;
        end else begin
            if (reg_rd) begin
                case (reg_addr)
                    8'd0:    m_rd = m_lo;
                    8'd1:    m_rd = m_hi;
                    8'd3:    m_rd = {30'd0, m_pend};
                    8'd5:    m_rd = {30'd0, m_en};
                    8'h47:   m_rd = {24'd0, dev_status};
                    default: m_rd = '0;
                endcase
            end
            cm = (reg_wr && reg_addr == 8'd7) ? reg_wdata[1:0] : 2'b00;
            if (reg_rd && reg_addr == 8'h47 && !dev_status[7] &&
                (dev_status & 8'h51) != 0)
                cm = 2'b11;
            if (buserr_evt && (!m_pend[1] || cm[1])) begin
                m_lo = buserr_addr[31:0];
                m_hi = buserr_addr[63:32];
            end
            m_pend = (m_pend & ~cm) | {buserr_evt, done_evt};
            if (reg_wr && reg_addr == 8'd5)
                m_en = reg_wdata[1:0];
        end
    end

    always @(posedge clk) begin
        #1;
        checks++;
        if (irq !== |(m_pend & m_en)) begin
            fails++;
            $display("FAIL R3 model irq: got %0b exp %0b", irq, |(m_pend & m_en));
        end
        checks++;
        if (reg_rdata !== m_rd) begin
            fails++;
            $display("FAIL R11 model rdata: got %h exp %h", reg_rdata, m_rd);
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        reg_wr = 0; reg_rd = 0; done_evt = 0; buserr_evt = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1; step();
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1; step(); d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 0);
        rd(8'd3, v); chk("R1 pending", v, 0);
        rd(8'd0, v); chk("R1 addr lo", v, 0);
        rd(8'd5, v); chk("R1 enable", v, 0);
        // R3 enable write/read
        wr(8'd5, 32'hFFFF_FFFF);
        rd(8'd5, v); chk("R3 enable readback", v, 3);
        // R2 done sets bit 0
        done_evt = 1; step();
        chk("R3 irq on done", {31'd0, irq}, 1);
        rd(8'd3, v); chk("R2 done pending", v, 1);
        // R4 write-one-to-clear per bit
        wr(8'd7, 32'h2);
        rd(8'd3, v); chk("R4 zero bit keeps", v, 1);
        wr(8'd7, 32'h1);
        rd(8'd3, v); chk("R4 one bit clears", v, 0);
        chk("R3 irq low after clear", {31'd0, irq}, 0);
        // R6 capture on first error
        buserr_addr = 64'h1234_5678_9ABC_DEF0; buserr_evt = 1; step();
        rd(8'd3, v); chk("R2 buserr pending", v, 2);
        rd(8'd0, v); chk("R6 addr lo", v, 32'h9ABC_DEF0);
        rd(8'd1, v); chk("R6 addr hi", v, 32'h1234_5678);
        // R7 later error ignored
        buserr_addr = 64'hAAAA_BBBB_CCCC_DDDD; buserr_evt = 1; step();
        rd(8'd0, v); chk("R7 addr lo held", v, 32'h9ABC_DEF0);
        rd(8'd1, v); chk("R7 addr hi held", v, 32'h1234_5678);
        // R5 event wins over clear; R6 capture while bit being cleared
        buserr_addr = 64'h0000_0001_0000_0002;
        reg_addr = 8'd7; reg_wdata = 32'h3; reg_wr = 1;
        buserr_evt = 1; done_evt = 1; step();
        rd(8'd3, v); chk("R5 event beats clear", v, 3);
        rd(8'd0, v); chk("R6 capture during clear", v, 32'h2);
        // R3 disabled sources do not raise irq
        wr(8'd5, 32'h0);
        chk("R3 irq masked", {31'd0, irq}, 0);
        wr(8'd5, 32'h2);
        chk("R3 irq bit1 only", {31'd0, irq}, 1);
        // R10 busy status read does not acknowledge
        dev_status = 8'hD0;
        rd(8'h47, v); chk("R8 devstat value", v, 32'hD0);
        rd(8'd3, v); chk("R10 busy no ack", v, 3);
        // R10 no flag bits, no acknowledge
        dev_status = 8'h08;
        rd(8'h47, v); chk("R8 devstat value 2", v, 32'h08);
        rd(8'd3, v); chk("R10 noflag no ack", v, 3);
        // R11 unmapped read returns zero and has no side effect
        rd(8'd2, v); chk("R11 unmapped zero", v, 0);
        rd(8'd3, v); chk("R10 other read keeps", v, 3);
        // R9 idle + flag clears both
        dev_status = 8'h50;
        rd(8'h47, v); chk("R8 devstat value 3", v, 32'h50);
        rd(8'd3, v); chk("R9 auto ack", v, 0);
        chk("R9 irq low", {31'd0, irq}, 0);
        // R9/R5 event same cycle as status-read ack
        dev_status = 8'h01; done_evt = 1; reg_addr = 8'h47; reg_rd = 1; step();
        rd(8'd3, v); chk("R9 event beats ack", v, 1);
        // R11 rdata holds between reads
        step();
        chk("R11 rdata hold", reg_rdata, 1);
        repeat (3) step();
        done_run = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule